// File: doc/BRIEF.md
# Lookahead Adder-Subtractor with Signed Overflow

This block adds or subtracts two unsigned-or-signed operands of a parameterised width in one pass of combinational logic. A single mode bit chooses the operation. When it is low, the block forms the sum of the two operands. When it is high, it forms the first operand minus the second in two's complement. It does this by complementing every bit of the second operand and feeding the mode bit in as the carry into bit zero. The same datapath serves both operations.

Carries are not rippled bit by bit. Each run of four bits forms its internal carries as sums of products of per-bit generate and propagate terms and the carry entering the run. Each run also reports a run-level generate and propagate pair. Those pairs link the runs so that the carry entering every run is known without waiting for the sum bits below it.

Three results are produced:
- the result word;
- the raw carry out of the top bit, which in subtract mode reads 1 when no borrow occurred;
- a signed overflow flag, taken as the difference between the carry into the top bit and the carry out of it.

The width must be a multiple of four.

Top module: `lookahead_addsub`

## Requirements
- R1: With sub_mode = 0, result equals (op_a + op_b) modulo 2^WIDTH.
- R2: With sub_mode = 1, result equals (op_a - op_b) modulo 2^WIDTH.
- R3: With sub_mode = 0, carry_out equals bit WIDTH of the unrounded sum op_a + op_b.
- R4: With sub_mode = 1, carry_out is 1 exactly when op_a >= op_b taken as unsigned numbers (no borrow).
- R5: With sub_mode = 0, ovf is 1 exactly when the signed sum of the operands (bit WIDTH-1 as sign) lies outside the signed WIDTH-bit range.
- R6: With sub_mode = 1, ovf is 1 exactly when the signed difference op_a - op_b lies outside the signed WIDTH-bit range.
- R7: A carry generated at bit 0 reaches every four-bit run. An all-ones op_a plus 1 gives result 0, carry_out 1 and ovf 0. Zero minus 1 gives all ones, carry_out 0 and ovf 0.
- R8: Subtracting zero returns op_a unchanged with carry_out 1 and ovf 0, including when op_a is the most negative value.
- R9: At the signed extremes, these cases hold. The most positive value plus 1 gives the most negative value with ovf 1. The most negative value minus 1 gives the most positive value with ovf 1. Zero minus the most negative value gives the most negative value with ovf 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit; in subtract mode 1 means no borrow |
| ovf | output | 1 | Signed overflow of the selected operation |

## Verification
Every result of this block is combinational, so result, carry_out and ovf are all due in the same cycle as the operands, with no register in between. The driver applies a new operand pair and mode just after a rising edge and queues the expected triple. The monitor takes that triple from the queue and compares it at the following falling edge, half a period later, when the logic has settled and before the next stimulus arrives. Expected values come from plain integer addition, subtraction, an unsigned magnitude compare and a signed range test, not from any carry logic.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int unsigned GROUP_W = 4;

  // Carries into the four bits of one run, each a sum of products of the
  // per-bit generate/propagate terms and the carry entering the run.
  function automatic logic [GROUP_W-1:0] run_carries(
    input logic [GROUP_W-1:0] g,
    input logic [GROUP_W-1:0] p,
    input logic               cin
  );
    logic [GROUP_W-1:0] c;
    c[0] = cin;
    c[1] = g[0] | (p[0] & cin);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
         | (p[2] & p[1] & p[0] & cin);
    return c;
  endfunction

  // Run-level generate: the run produces a carry on its own.
  function automatic logic run_generate(
    input logic [GROUP_W-1:0] g,
    input logic [GROUP_W-1:0] p
  );
    return g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
         | (p[3] & p[2] & p[1] & g[0]);
  endfunction

  // Run-level propagate: an entering carry passes straight through.
  function automatic logic run_propagate(input logic [GROUP_W-1:0] p);
    return &p;
  endfunction

endpackage

// File: rtl/addsub_bit_prep.sv
module addsub_bit_prep #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] bit_g,
  output logic [WIDTH-1:0] bit_p
);

  logic [WIDTH-1:0] b_cond;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_cond[i] = op_b[i] ^ sub_mode;
    assign bit_g[i]  = op_a[i] & b_cond[i];
    assign bit_p[i]  = op_a[i] ^ b_cond[i];
  end

  // R2: in subtract mode a position can generate only where a=1 and b=0
  always_comb begin
    if (sub_mode) begin
      a_r2_sub_generate: assert ((bit_g & ~(op_a & ~op_b)) == '0);
    end
    a_r1_gp_exclusive: assert ((bit_g & bit_p) == '0);
  end

endmodule

// File: rtl/addsub_cla_group.sv
module addsub_cla_group
  import addsub_pkg::*;
(
  input  logic [GROUP_W-1:0] bit_g,
  input  logic [GROUP_W-1:0] bit_p,
  input  logic               c_in,
  output logic [GROUP_W-1:0] c_bit,
  output logic               grp_g,
  output logic               grp_p
);

  assign c_bit = run_carries(bit_g, bit_p, c_in);
  assign grp_g = run_generate(bit_g, bit_p);
  assign grp_p = run_propagate(bit_p);

  // R7: a run that propagates everywhere hands its entering carry to every bit
  always_comb begin
    if (grp_p) begin
      a_r7_run_pass: assert (c_bit == {GROUP_W{c_in}} && !grp_g);
    end
    if (bit_g[0]) begin
      a_r7_low_gen: assert (c_bit[1]);
    end
  end

endmodule

// File: rtl/addsub_group_link.sv
module addsub_group_link #(
  parameter int unsigned N_GROUPS = 4
) (
  input  logic [N_GROUPS-1:0] grp_g,
  input  logic [N_GROUPS-1:0] grp_p,
  input  logic                c_in,
  output logic [N_GROUPS:0]   grp_c
);

  assign grp_c[0] = c_in;
  for (genvar k = 0; k < N_GROUPS; k++) begin : g_link
    assign grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
  end

  // R7: a generating run always passes a carry upward
  always_comb begin
    for (int k = 0; k < N_GROUPS; k++) begin
      if (grp_g[k]) begin
        a_r7_link_gen: assert (grp_c[k+1]);
      end
    end
  end

endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);

  localparam int unsigned N_GROUPS = WIDTH / GROUP_W;

  logic [WIDTH-1:0]    bit_g;
  logic [WIDTH-1:0]    bit_p;
  logic [WIDTH-1:0]    bit_c;
  logic [N_GROUPS-1:0] grp_g;
  logic [N_GROUPS-1:0] grp_p;
  logic [N_GROUPS:0]   grp_c;
  logic                carry_into_msb;

  addsub_bit_prep #(.WIDTH(WIDTH)) u_prep (
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_mode (sub_mode),
    .bit_g    (bit_g),
    .bit_p    (bit_p)
  );

  for (genvar k = 0; k < N_GROUPS; k++) begin : g_grp
    addsub_cla_group u_grp (
      .bit_g (bit_g[GROUP_W*k +: GROUP_W]),
      .bit_p (bit_p[GROUP_W*k +: GROUP_W]),
      .c_in  (grp_c[k]),
      .c_bit (bit_c[GROUP_W*k +: GROUP_W]),
      .grp_g (grp_g[k]),
      .grp_p (grp_p[k])
    );
  end

  addsub_group_link #(.N_GROUPS(N_GROUPS)) u_link (
    .grp_g (grp_g),
    .grp_p (grp_p),
    .c_in  (sub_mode),
    .grp_c (grp_c)
  );

  assign carry_into_msb = bit_c[WIDTH-1];
  assign result         = bit_p ^ bit_c;
  assign carry_out      = grp_c[N_GROUPS];
  assign ovf            = carry_into_msb ^ carry_out;

  // Checks against plain arithmetic, independent of the carry network
  always_comb begin
    logic [WIDTH:0] ref_add;
    logic [WIDTH-1:0] ref_sub;
    ref_add = {1'b0, op_a} + {1'b0, op_b};
    ref_sub = op_a - op_b;
    if (!sub_mode) begin
      a_r1_add_result: assert (result == ref_add[WIDTH-1:0]);
      a_r3_add_carry:  assert (carry_out == ref_add[WIDTH]);
      a_r5_add_ovf:    assert (ovf == ((op_a[WIDTH-1] == op_b[WIDTH-1]) &&
                                       (result[WIDTH-1] != op_a[WIDTH-1])));
    end else begin
      a_r2_sub_result: assert (result == ref_sub);
      a_r4_sub_carry:  assert (carry_out == (op_a >= op_b));
      a_r6_sub_ovf:    assert (ovf == ((op_a[WIDTH-1] != op_b[WIDTH-1]) &&
                                       (result[WIDTH-1] != op_a[WIDTH-1])));
      if (op_b == '0) begin
        a_r8_sub_zero: assert (carry_out && !ovf);
      end
    end
  end

endmodule

// File: tb/lookahead_addsub_tb_top.sv
module lookahead_addsub_tb_top;

  localparam int W = 16;
  localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAXNEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES   = {W{1'b1}};

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         ov;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         ovf;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  lookahead_addsub #(.WIDTH(W)) dut_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_mode  (sub_mode),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 50000", cycles);
      finish_run();
    end
  end

  // Driver: apply stimulus just after the edge, queue the expected triple
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic m, input string tag);
    exp_t e;
    longint sa, sb, sr;
    @(posedge clk);
    #1;
    op_a = a;
    op_b = b;
    sub_mode = m;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (!m) begin
      e.res = a + b;
      e.cy  = (longint'(a) + longint'(b)) >= (longint'(1) << W);
      sr    = sa + sb;
    end else begin
      e.res = a - b;
      e.cy  = (a >= b);
      sr    = sa - sb;
    end
    e.ov  = (sr > longint'(MAXPOS)) || (sr < -(longint'(1) << (W-1)));
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compare half a period after stimulus
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (result !== e.res) begin
        n_fail++;
        $display("FAIL %s result: actual %h expected %h", e.tag, result, e.res);
      end
      n_checks++;
      if (carry_out !== e.cy) begin
        n_fail++;
        $display("FAIL %s carry_out: actual %b expected %b", e.tag, carry_out, e.cy);
      end
      n_checks++;
      if (ovf !== e.ov) begin
        n_fail++;
        $display("FAIL %s ovf: actual %b expected %b", e.tag, ovf, e.ov);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: zero operands, add mode
    drive('0, '0, 1'b0, "R1_idle");
    drive(16'h1234, 16'h4321, 1'b0, "R1");
    drive(16'h0003, 16'h0001, 1'b0, "R3");
    drive(16'hF000, 16'h1000, 1'b0, "R3");
    drive(16'h1234, 16'h0234, 1'b1, "R2");
    drive(16'h0005, 16'h0009, 1'b1, "R4");
    drive(16'h0009, 16'h0009, 1'b1, "R4");
    drive(16'h4000, 16'h4000, 1'b0, "R5");
    drive(16'hC000, 16'hBFFF, 1'b0, "R5");
    drive(16'h8000, 16'h8000, 1'b0, "R5");
    drive(16'h4000, 16'hC000, 1'b1, "R6");
    drive(16'hC000, 16'h4001, 1'b1, "R6");
    drive(ONES, 16'h0001, 1'b0, "R7");
    drive('0, 16'h0001, 1'b1, "R7");
    drive(16'h0FFF, 16'h0001, 1'b0, "R7");
    drive(16'hA5A5, '0, 1'b1, "R8");
    drive(MAXNEG, '0, 1'b1, "R8");
    drive(MAXPOS, 16'h0001, 1'b0, "R9");
    drive(MAXNEG, 16'h0001, 1'b1, "R9");
    drive('0, MAXNEG, 1'b1, "R9");
    drive(MAXNEG, MAXPOS, 1'b1, "R9");
    drive(MAXPOS, MAXPOS, 1'b0, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      logic rm;
      ra = W'($urandom);
      rb = W'($urandom);
      rm = 1'($urandom);
      drive(ra, rb, rm, rm ? "R2_R4_R6_rand" : "R1_R3_R5_rand");
    end
    @(posedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule